// File: doc/BRIEF.md
# Ring Detect Status Reporter

This block turns two digital comparator flags from a phone-line front end into ring status. One flag says the line voltage sits above the positive ring threshold, the other says it sits below the negative one. The block re-times both flags into the local clock. It reports each flag as a live status bit. It also keeps a retriggerable ring indicator that stays set for a programmable number of millisecond ticks after the last qualifying ring edge.

A full-wave control selects which edges qualify. With full-wave off, only positive swings count. With full-wave on, both polarities count. While the line is on-hook, the block replaces the audio sample stream with fixed sentinel codes, so that a downstream sample consumer can see ring activity without reading status. While off-hook, it forwards the normal audio samples and holds the ring indicator clear.

Top module: `ring_status_top`

## Requirements
- R1: `pos_stat_o` equals `pos_cmp_i` delayed by SYNC_STAGES clock edges, and `neg_stat_o` equals `neg_cmp_i` delayed the same way. Both are low when neither flag is high.
- R2: With `full_wave_i` low, a rising edge on the re-timed negative flag is not a ring event, so it neither sets nor reloads `ring_ind_o`.
- R3: With `full_wave_i` high, a rising edge on either re-timed flag is a ring event.
- R4: A ring event while on-hook sets `ring_ind_o` on the next clock edge and reloads the hold count to HOLD_TICKS. A flag held high produces only one event, at its rising edge.
- R5: `ring_ind_o` falls only after HOLD_TICKS cycles of `ms_tick_i` with no new event, or through R6.
- R6: While `on_hook_i` is low, `ring_ind_o` is cleared on the next edge and stays low.
- R7: On-hook with full-wave low, `sample_o` becomes 16'h7FFF (+32767) one edge after the re-timed positive flag is high, and 16'h8000 (-32768) otherwise. The negative flag has no effect.
- R8: On-hook with full-wave high, `sample_o` becomes 16'h7FFF on a positive flag, 16'h8000 on a negative flag only, and 16'h04CC (+1228) with neither. Positive takes priority.
- R9: Off-hook, `sample_o` equals `audio_i` from the previous clock edge.
- R10: During and right after reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pos_cmp_i | input | 1 | Line above positive ring threshold |
| neg_cmp_i | input | 1 | Line below negative ring threshold |
| full_wave_i | input | 1 | 1: both polarities count as ring events |
| on_hook_i | input | 1 | 1: line on-hook |
| ms_tick_i | input | 1 | One-cycle pulse every millisecond |
| audio_i | input | 16 | Normal audio sample |
| pos_stat_o | output | 1 | Live positive ring status |
| neg_stat_o | output | 1 | Live negative ring status |
| ring_ind_o | output | 1 | Retriggerable ring indicator |
| sample_o | output | 16 | Audio sample or ring sentinel code |

## Verification
The bench builds the block with SYNC_STAGES=2 and HOLD_TICKS=20, and drives a tick every fourth cycle. A hold window therefore lasts 80 cycles instead of five seconds. This brings expiry, reload while active, and a flag held longer than the window into reach many times within a short run. The two-stage re-timing path stays as in the default build, so the cycle offsets between the comparator inputs, the status bits, the indicator and the sentinel samples are checked exactly as they appear in the full-size block.

// File: rtl/ring_pkg.sv
package ring_pkg;
  localparam int SAMPLE_W = 16;
  typedef logic [SAMPLE_W-1:0] sample_t;

  localparam sample_t CODE_POS_RING = 16'h7FFF;
  localparam sample_t CODE_NEG_RING = 16'h8000;
  localparam sample_t CODE_IDLE_HW  = 16'h8000;
  localparam sample_t CODE_IDLE_FW  = 16'h04CC;

  typedef struct packed {
    logic pos;
    logic neg;
  } ring_flags_t;
endpackage

// File: rtl/ring_sync.sv
module ring_sync #(
  parameter int STAGES = 2,
  parameter int W      = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
    end else begin : g_chain
      logic [W-1:0] stage_q [STAGES];
      logic [W-1:0] stage_d [STAGES];
      for (genvar i = 0; i < STAGES; i++) begin : g_st
        if (i == 0) begin : g_first
          assign stage_d[i] = d_i;
        end else begin : g_next
          assign stage_d[i] = stage_q[i-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[i] <= '0;
          else        stage_q[i] <= stage_d[i];
        end
      end
      assign q_o = stage_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/ring_edge_qual.sv
module ring_edge_qual
  import ring_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  ring_flags_t flags_i,
  input  logic        full_wave_i,
  output logic        evt_o
);
  ring_flags_t prev_q, prev_d;
  logic        pos_rise, neg_rise;

  always_comb begin
    prev_d = flags_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  assign pos_rise = flags_i.pos & ~prev_q.pos;
  assign neg_rise = flags_i.neg & ~prev_q.neg;
  assign evt_o    = pos_rise | (full_wave_i & neg_rise);

  // a level held high yields an event only in its first cycle (R4)
  assert_single_evt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_o && flags_i.pos && !flags_i.neg) |=> (flags_i.pos |-> !evt_o || flags_i.neg));
endmodule

// File: rtl/ring_oneshot.sv
module ring_oneshot #(
  parameter int HOLD_TICKS = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic on_hook_i,
  input  logic tick_i,
  output logic ring_o
);
  localparam int CW = $clog2(HOLD_TICKS + 1);
  localparam logic [CW-1:0] LOAD = CW'(HOLD_TICKS);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (!on_hook_i) begin
      cnt_d  = '0;
      cnt_en = (cnt_q != '0);
    end else if (evt_i) begin
      cnt_d  = LOAD;
      cnt_en = 1'b1;
    end else if (tick_i && (cnt_q != '0)) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign ring_o = (cnt_q != '0);

  assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i && on_hook_i) |=> ring_o);
  assert_rise_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ring_o) |-> $past(evt_i && on_hook_i));
  assert_fall_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ring_o) |-> $past(tick_i || !on_hook_i));
  assert_offhook_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !on_hook_i |=> !ring_o);
endmodule

// File: rtl/ring_sample_mux.sv
module ring_sample_mux
  import ring_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  ring_flags_t flags_i,
  input  logic        full_wave_i,
  input  logic        on_hook_i,
  input  sample_t     audio_i,
  output sample_t     sample_o
);
  sample_t samp_q, samp_d;

  always_comb begin
    if (!on_hook_i)        samp_d = audio_i;
    else if (flags_i.pos)  samp_d = CODE_POS_RING;
    else if (full_wave_i)  samp_d = flags_i.neg ? CODE_NEG_RING : CODE_IDLE_FW;
    else                   samp_d = CODE_IDLE_HW;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) samp_q <= '0;
    else        samp_q <= samp_d;
  end

  assign sample_o = samp_q;

  assert_passthru_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !on_hook_i |=> (sample_o == $past(audio_i)));
  assert_hw_neg_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (on_hook_i && !full_wave_i && !flags_i.pos) |=> (sample_o == CODE_IDLE_HW));
  assert_fw_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (on_hook_i && full_wave_i && !flags_i.pos && !flags_i.neg) |=> (sample_o == CODE_IDLE_FW));
endmodule

// File: rtl/ring_status_top.sv
module ring_status_top
  import ring_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_TICKS  = 5000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pos_cmp_i,
  input  logic        neg_cmp_i,
  input  logic        full_wave_i,
  input  logic        on_hook_i,
  input  logic        ms_tick_i,
  input  logic [15:0] audio_i,
  output logic        pos_stat_o,
  output logic        neg_stat_o,
  output logic        ring_ind_o,
  output logic [15:0] sample_o
);
  ring_flags_t raw_flags, sync_flags;
  logic        ring_evt;

  assign raw_flags.pos = pos_cmp_i;
  assign raw_flags.neg = neg_cmp_i;

  ring_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw_flags),
    .q_o   (sync_flags)
  );

  ring_edge_qual u_edge (
    .clk         (clk),
    .rst_n       (rst_n),
    .flags_i     (sync_flags),
    .full_wave_i (full_wave_i),
    .evt_o       (ring_evt)
  );

  ring_oneshot #(.HOLD_TICKS(HOLD_TICKS)) u_oneshot (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (ring_evt),
    .on_hook_i (on_hook_i),
    .tick_i    (ms_tick_i),
    .ring_o    (ring_ind_o)
  );

  ring_sample_mux u_mux (
    .clk         (clk),
    .rst_n       (rst_n),
    .flags_i     (sync_flags),
    .full_wave_i (full_wave_i),
    .on_hook_i   (on_hook_i),
    .audio_i     (audio_i),
    .sample_o    (sample_o)
  );

  assign pos_stat_o = sync_flags.pos;
  assign neg_stat_o = sync_flags.neg;

  assert_hw_neg_no_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_wave_i && !pos_stat_o && on_hook_i && !ring_ind_o) |=> !ring_ind_o);
endmodule

// File: tb/ring_status_top_tb.sv
module ring_status_top_tb;
  localparam int SYNC = 2;
  localparam int HOLD = 20;
  localparam int TICK_DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        pos_cmp, neg_cmp, full_wave, on_hook, ms_tick;
  logic [15:0] audio;
  logic        pos_stat, neg_stat, ring_ind;
  logic [15:0] sample;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always #5ns clk = ~clk;

  ring_status_top #(.SYNC_STAGES(SYNC), .HOLD_TICKS(HOLD)) u_dut (
    .clk(clk), .rst_n(rst_n), .pos_cmp_i(pos_cmp), .neg_cmp_i(neg_cmp),
    .full_wave_i(full_wave), .on_hook_i(on_hook), .ms_tick_i(ms_tick),
    .audio_i(audio), .pos_stat_o(pos_stat), .neg_stat_o(neg_stat),
    .ring_ind_o(ring_ind), .sample_o(sample)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic logic [15:0] exp_sample(input logic oh, input logic fw,
                                             input logic p, input logic n,
                                             input logic [15:0] a);
    if (!oh)     return a;
    if (p)       return 16'h7FFF;
    if (fw && n) return 16'h8000;
    if (fw)      return 16'h04CC;
    return 16'h8000;
  endfunction

  // reference model built from the requirements
  logic [SYNC-1:0] m_p, m_n;
  logic            m_pprev, m_nprev;
  int              m_cnt;
  logic [15:0]     m_samp;
  logic            m_evt;

  assign m_evt = (m_p[SYNC-1] & ~m_pprev) | (full_wave & m_n[SYNC-1] & ~m_nprev);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_p <= '0; m_n <= '0; m_pprev <= 1'b0; m_nprev <= 1'b0;
      m_cnt <= 0; m_samp <= '0;
    end else begin
      m_p     <= {m_p[SYNC-2:0], pos_cmp};
      m_n     <= {m_n[SYNC-2:0], neg_cmp};
      m_pprev <= m_p[SYNC-1];
      m_nprev <= m_n[SYNC-1];
      if (!on_hook)                 m_cnt <= 0;
      else if (m_evt)               m_cnt <= HOLD;
      else if (ms_tick && m_cnt > 0) m_cnt <= m_cnt - 1;
      m_samp <= exp_sample(on_hook, full_wave, m_p[SYNC-1], m_n[SYNC-1], audio);
    end
  end

  always @(posedge clk) cyc <= cyc + 1;

  // tick generator
  int tdiv = 0;
  always @(negedge clk) begin
    tdiv    = (tdiv + 1) % TICK_DIV;
    ms_tick = (tdiv == 0);
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R1 pos_stat", {15'd0, pos_stat}, {15'd0, m_p[SYNC-1]});
      chk("R1 neg_stat", {15'd0, neg_stat}, {15'd0, m_n[SYNC-1]});
      chk("R4 ring_ind", {15'd0, ring_ind}, {15'd0, m_cnt > 0});
      chk("R7/R8/R9 sample", sample, m_samp);
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd1357));
    rst_n = 1'b0; pos_cmp = 0; neg_cmp = 0; full_wave = 0; on_hook = 1;
    audio = 16'h0000; ms_tick = 0;
    step(3);
    chk("R10 ring_ind", {15'd0, ring_ind}, 16'd0);
    chk("R10 sample", sample, 16'd0);
    rst_n = 1'b1;
    chk("R10 pos_stat", {15'd0, pos_stat}, 16'd0);
    chk("R10 neg_stat", {15'd0, neg_stat}, 16'd0);

    step(4);
    chk("R7 idle half-wave", sample, 16'h8000);
    pos_cmp = 1; step(4);
    chk("R1 pos high", {15'd0, pos_stat}, 16'd1);
    chk("R7 pos ring", sample, 16'h7FFF);
    chk("R4 set on event", {15'd0, ring_ind}, 16'd1);
    pos_cmp = 0; step(4);
    chk("R7 back idle", sample, 16'h8000);
    neg_cmp = 1; step(4);
    chk("R1 neg high", {15'd0, neg_stat}, 16'd1);
    chk("R7 neg ignored", sample, 16'h8000);
    neg_cmp = 0;
    step(HOLD * TICK_DIV + 20);
    chk("R5 expired", {15'd0, ring_ind}, 16'd0);

    pos_cmp = 1; step(HOLD * TICK_DIV + 40);
    chk("R4 level no reload", {15'd0, ring_ind}, 16'd0);
    pos_cmp = 0; step(4);
    neg_cmp = 1; step(4);
    chk("R2 neg no event", {15'd0, ring_ind}, 16'd0);
    neg_cmp = 0; step(4);

    full_wave = 1; step(4);
    chk("R8 idle full-wave", sample, 16'h04CC);
    neg_cmp = 1; step(4);
    chk("R3 neg event", {15'd0, ring_ind}, 16'd1);
    chk("R8 neg ring", sample, 16'h8000);
    pos_cmp = 1; step(4);
    chk("R8 pos priority", sample, 16'h7FFF);
    pos_cmp = 0; neg_cmp = 0;

    on_hook = 0; audio = 16'h1234; step(2);
    chk("R6 off-hook clear", {15'd0, ring_ind}, 16'd0);
    chk("R9 passthru", sample, 16'h1234);
    pos_cmp = 1; step(4);
    chk("R6 held clear", {15'd0, ring_ind}, 16'd0);
    pos_cmp = 0; on_hook = 1; step(4);

    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(7) == 0)   pos_cmp   = ~pos_cmp;
      if ($urandom_range(7) == 0)   neg_cmp   = ~neg_cmp;
      if ($urandom_range(80) == 0)  full_wave = ~full_wave;
      if ($urandom_range(150) == 0) on_hook   = ~on_hook;
      audio = 16'($urandom);
      step(1);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule